// File: doc/BRIEF.md
# Multi-Policy Dueling Selector

This block picks, at run time, which of several cache insertion policies should be used by the bulk of a cache. A small group of sampled sets is permanently bound to each candidate policy; every other set is a follower and uses whichever policy is currently winning. The block keeps one signed score per policy. A miss in a set bound to policy j charges that policy heavily, adding N-1 to its score and taking 1 from every other score. The scores always sum to zero, and the policy with the lowest score wins.

The cache reports each miss with its set index. In the same cycle it may query the policy to apply to any set, for example the set being filled. Sampled sets always get their own policy back. Followers get the current winner. The block supports two, three or four policies through the NUM_POL parameter. It holds no cache arrays and performs no insertion.

Top module: `policy_duel_select`

## Requirements
- R1: While `rst` is high at a rising clock edge, every score is cleared to 0. The `winner` output is 0 in the cycle after reset.
- R2: A set is sampled for policy j (0 <= j < NUM_POL) when its index bits [4:0] equal j and its bits above bit 4 equal SAMPLE_TAG. For such a query set, `query_policy` equals j.
- R3: For any set that is not sampled, `query_policy` equals `winner`.
- R4: A miss (`miss_valid` high) in a set sampled for policy j adds NUM_POL-1 to score j and subtracts 1 from every other score at the next rising edge.
- R5: A miss in a follower set leaves every score unchanged.
- R6: Each score is a CTR_W-bit two's-complement value. If any score would leave that range on an update, none of the scores change.
- R7: `winner` is the index of the smallest score. A tie goes to the lowest index.
- R8: The scores always sum to zero.
- R9: When `miss_valid` is low, no score changes, whatever the value of `miss_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss occurred this cycle |
| miss_set | input | SET_BITS | Set index of the miss |
| query_set | input | SET_BITS | Set whose policy is requested |
| query_policy | output | 2 | Policy to apply in `query_set` |
| winner | output | 2 | Policy with the smallest score |

## Verification
The bench builds the block with three policies, 8-bit set indices, 6-bit scores and a sample tag of 5. With three policies, tie breaking is seen between all three scores, and set indices whose low field is 3 or more match the tag but must still act as followers. The narrow scores saturate after a few dozen misses. This makes the freeze on both the positive and the negative limit reachable, both in directed runs that hammer one policy or alternate between two, and in the random phase.

// File: rtl/policy_duel_pkg.sv
package policy_duel_pkg;

    // Width of the low index field that names the sampled policy
    localparam int IDX_LOW_BITS = 5;
    // Upper bound on the number of duelling policies
    localparam int MAX_POL = 4;

    typedef logic [1:0] pol_id_t;

    // Result of classifying one set index
    typedef struct packed {
        logic    dedicated;
        pol_id_t pol;
    } set_class_t;

endpackage

// File: rtl/policy_duel_classify.sv
module policy_duel_classify
    import policy_duel_pkg::*;
#(
    parameter int NUM_POL    = 3,
    parameter int SET_BITS   = 10,
    parameter int SAMPLE_TAG = 0
) (
    input  logic [SET_BITS-1:0] set_idx,
    output set_class_t          cls
);
    localparam int TAG_BITS = SET_BITS - IDX_LOW_BITS;

    logic [IDX_LOW_BITS-1:0] low_field;
    logic [TAG_BITS-1:0]     tag_field;

    always_comb begin
        low_field     = set_idx[IDX_LOW_BITS-1:0];
        tag_field     = set_idx[SET_BITS-1:IDX_LOW_BITS];
        cls.dedicated = (tag_field == TAG_BITS'(SAMPLE_TAG)) &&
                        (low_field < IDX_LOW_BITS'(NUM_POL));
        cls.pol       = low_field[1:0];
    end
endmodule

// File: rtl/policy_duel_counters.sv
module policy_duel_counters
    import policy_duel_pkg::*;
#(
    parameter int NUM_POL = 3,
    parameter int CTR_W   = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_en,
    input  pol_id_t                 upd_pol,
    output logic signed [CTR_W-1:0] ctr [NUM_POL]
);
    localparam int EXT    = CTR_W + 1;
    localparam int HI_INT = (1 << (CTR_W - 1)) - 1;
    localparam int LO_INT = -(1 << (CTR_W - 1));
    localparam logic signed [EXT-1:0] LIM_HI = EXT'(HI_INT);
    localparam logic signed [EXT-1:0] LIM_LO = EXT'(LO_INT);
    localparam logic signed [EXT-1:0] GAIN   = EXT'(NUM_POL - 1);
    localparam logic signed [EXT-1:0] ONE    = EXT'(1);

    logic signed [EXT-1:0] nxt [NUM_POL];
    logic [NUM_POL-1:0]    out_of_range;
    logic                  freeze;

    assign freeze = |out_of_range;

    for (genvar i = 0; i < NUM_POL; i++) begin : g_ctr
        logic signed [EXT-1:0] wide;

        always_comb begin
            wide = {ctr[i][CTR_W-1], ctr[i]};
            if (upd_pol == pol_id_t'(i))
                nxt[i] = wide + GAIN;
            else
                nxt[i] = wide - ONE;
            out_of_range[i] = (nxt[i] > LIM_HI) || (nxt[i] < LIM_LO);
        end

        always_ff @(posedge clk) begin
            if (rst)
                ctr[i] <= '0;
            else if (upd_en && !freeze)
                ctr[i] <= nxt[i][CTR_W-1:0];
        end
    end
endmodule

// File: rtl/policy_duel_argmin.sv
module policy_duel_argmin
    import policy_duel_pkg::*;
#(
    parameter int NUM_POL = 3,
    parameter int CTR_W   = 10
) (
    input  logic signed [CTR_W-1:0] ctr [NUM_POL],
    output pol_id_t                 best
);
    logic signed [CTR_W-1:0] best_val;

    // Strict comparison keeps the earlier index on a tie
    always_comb begin
        best     = '0;
        best_val = ctr[0];
        for (int i = 1; i < NUM_POL; i++) begin
            if (ctr[i] < best_val) begin
                best_val = ctr[i];
                best     = pol_id_t'(i);
            end
        end
    end
endmodule

// File: rtl/policy_duel_select.sv
module policy_duel_select
    import policy_duel_pkg::*;
#(
    parameter int NUM_POL    = 3,
    parameter int SET_BITS   = 10,
    parameter int CTR_W      = 10,
    parameter int SAMPLE_TAG = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                miss_valid,
    input  logic [SET_BITS-1:0] miss_set,
    input  logic [SET_BITS-1:0] query_set,
    output logic [1:0]          query_policy,
    output logic [1:0]          winner
);
    set_class_t              miss_cls;
    set_class_t              query_cls;
    pol_id_t                 best;
    logic signed [CTR_W-1:0] ctr_q [NUM_POL];

    policy_duel_classify #(
        .NUM_POL(NUM_POL), .SET_BITS(SET_BITS), .SAMPLE_TAG(SAMPLE_TAG)
    ) u_miss_cls (
        .set_idx(miss_set),
        .cls    (miss_cls)
    );

    policy_duel_classify #(
        .NUM_POL(NUM_POL), .SET_BITS(SET_BITS), .SAMPLE_TAG(SAMPLE_TAG)
    ) u_query_cls (
        .set_idx(query_set),
        .cls    (query_cls)
    );

    policy_duel_counters #(
        .NUM_POL(NUM_POL), .CTR_W(CTR_W)
    ) u_scores (
        .clk    (clk),
        .rst    (rst),
        .upd_en (miss_valid && miss_cls.dedicated),
        .upd_pol(miss_cls.pol),
        .ctr    (ctr_q)
    );

    policy_duel_argmin #(
        .NUM_POL(NUM_POL), .CTR_W(CTR_W)
    ) u_pick (
        .ctr (ctr_q),
        .best(best)
    );

    assign winner       = best;
    assign query_policy = query_cls.dedicated ? query_cls.pol : best;
endmodule

// File: rtl/policy_duel_checker.sv
module policy_duel_checker #(
    parameter int NUM_POL    = 3,
    parameter int SET_BITS   = 10,
    parameter int CTR_W      = 10,
    parameter int SAMPLE_TAG = 0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    miss_valid,
    input logic [SET_BITS-1:0]     miss_set,
    input logic [SET_BITS-1:0]     query_set,
    input logic [1:0]              query_policy,
    input logic [1:0]              winner,
    input logic signed [CTR_W-1:0] ctr_q [NUM_POL]
);
    logic [NUM_POL*CTR_W-1:0] flat;
    int                       total;
    logic                     win_ok;
    logic                     miss_sampled;
    logic                     query_sampled;
    logic signed [CTR_W-1:0]  win_val;

    always_comb begin
        total   = 0;
        win_val = ctr_q[0];
        for (int i = 0; i < NUM_POL; i++) begin
            total = total + int'(ctr_q[i]);
            flat[i*CTR_W +: CTR_W] = ctr_q[i];
            if (int'(winner) == i) win_val = ctr_q[i];
        end
        win_ok = int'(winner) < NUM_POL;
        for (int i = 0; i < NUM_POL; i++) begin
            if (i < int'(winner) && !(ctr_q[i] > win_val)) win_ok = 1'b0;
            if (i > int'(winner) && ctr_q[i] < win_val)    win_ok = 1'b0;
        end
        miss_sampled  = (int'(miss_set >> 5) == SAMPLE_TAG) &&
                        (int'(miss_set[4:0]) < NUM_POL);
        query_sampled = (int'(query_set >> 5) == SAMPLE_TAG) &&
                        (int'(query_set[4:0]) < NUM_POL);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flat == '0) && (winner == 2'd0));

    // R8
    zero_sum_chk: assert property (@(posedge clk) disable iff (rst)
        total == 0);

    // R7
    winner_min_chk: assert property (@(posedge clk) disable iff (rst)
        win_ok);

    // R2
    query_sampled_chk: assert property (@(posedge clk) disable iff (rst)
        query_sampled |-> query_policy == query_set[1:0]);

    // R3
    query_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !query_sampled |-> query_policy == winner);

    // R5
    follower_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !miss_sampled) |=> $stable(flat));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !miss_valid |=> $stable(flat));
endmodule

bind policy_duel_select policy_duel_checker #(
    .NUM_POL(NUM_POL), .SET_BITS(SET_BITS), .CTR_W(CTR_W), .SAMPLE_TAG(SAMPLE_TAG)
) chk (
    .clk         (clk),
    .rst         (rst),
    .miss_valid  (miss_valid),
    .miss_set    (miss_set),
    .query_set   (query_set),
    .query_policy(query_policy),
    .winner      (winner),
    .ctr_q       (ctr_q)
);

// File: tb/policy_duel_select_test.sv
module policy_duel_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 3;
    localparam int SB   = 8;
    localparam int CW   = 6;
    localparam int TAG  = 5;
    localparam int HI   = (1 << (CW - 1)) - 1;
    localparam int LO   = -(1 << (CW - 1));
    localparam int BASE = TAG * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic [SB-1:0] miss_set = '0;
    logic [SB-1:0] query_set = '0;
    logic [1:0]    query_policy;
    logic [1:0]    winner;

    int total = 0;
    int bad = 0;
    int model [NP];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    policy_duel_select #(
        .NUM_POL(NP), .SET_BITS(SB), .CTR_W(CW), .SAMPLE_TAG(TAG)
    ) uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_set(miss_set),
        .query_set(query_set), .query_policy(query_policy), .winner(winner)
    );

    function automatic int sampled_pol(input int s);
        if ((s / 32) == TAG && (s % 32) < NP) return s % 32;
        return -1;
    endfunction

    function automatic int exp_winner();
        int b = 0;
        for (int i = 1; i < NP; i++) if (model[i] < model[b]) b = i;
        return b;
    endfunction

    function automatic void model_miss(input int s);
        int j = sampled_pol(s);
        int nx [NP];
        bit ok = 1'b1;
        if (j < 0) return;
        for (int i = 0; i < NP; i++) begin
            nx[i] = (i == j) ? model[i] + NP - 1 : model[i] - 1;
            if (nx[i] > HI || nx[i] < LO) ok = 1'b0;
        end
        if (ok) for (int i = 0; i < NP; i++) model[i] = nx[i];
    endfunction

    function automatic int exp_query(input int s);
        int j = sampled_pol(s);
        return (j >= 0) ? j : exp_winner();
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        miss_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NP; i++) model[i] = 0;
    endtask

    // Drive one cycle, then check both outputs after the edge
    task automatic step(input string req, input bit v, input int ms, input int qs);
        miss_valid = v;
        miss_set   = SB'(ms);
        query_set  = SB'(qs);
        @(posedge clk);
        if (v) model_miss(ms);
        @(negedge clk);
        check(req, int'(winner), exp_winner());
        check(req, int'(query_policy), exp_query(qs));
    endtask

    initial begin
        void'($urandom(17));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1", int'(winner), 0);
        query_set = SB'(3);
        #1 check("R1", int'(query_policy), 0);

        // R2 sampled sets report their own policy
        for (int j = 0; j < NP; j++) step("R2", 1'b0, 0, BASE + j);
        // R3 low field beyond NP, and tag mismatch, act as followers
        step("R3", 1'b0, 0, BASE + 3);
        step("R3", 1'b0, 0, 1);

        // R4 directed updates
        step("R4", 1'b1, BASE + 1, 0);
        check("R4", int'(winner), 0);
        step("R4", 1'b1, BASE + 0, 0);
        check("R4", int'(winner), 2);

        // R5 follower misses do nothing
        step("R5", 1'b1, 1, BASE + 1);
        step("R5", 1'b1, BASE + 3, 0);
        step("R5", 1'b1, 2, 2);
        check("R5", int'(winner), 2);
        // R9 idle cycles ignore miss_set
        step("R9", 1'b0, BASE + 2, 0);
        step("R9", 1'b0, BASE + 2, 0);
        check("R9", int'(winner), 2);

        // R6 positive limit: hammer policy 0 until frozen
        do_reset();
        for (int k = 0; k < 20; k++) step("R6", 1'b1, BASE + 0, 3);
        check("R6", int'(winner), 1);
        step("R6", 1'b1, BASE + 1, 3);
        check("R6", int'(winner), 2);

        // R6 negative limit: alternate policies 1 and 2
        do_reset();
        for (int k = 0; k < 40; k++) step("R6", 1'b1, BASE + 1 + (k % 2), 0);
        check("R6", model[0], LO);

        // R7 tie break: equal scores 1 and 2
        do_reset();
        step("R7", 1'b1, BASE + 0, 7);
        check("R7", int'(winner), 1);

        // R4 R7 R8 random traffic against the model
        do_reset();
        for (int k = 0; k < 3000; k++) begin
            int ms;
            int qs;
            if ($urandom % 2 == 0) ms = BASE + int'($urandom % NP);
            else ms = int'($urandom % 256);
            if ($urandom % 2 == 0) qs = BASE + int'($urandom % 4);
            else qs = int'($urandom % 256);
            step("R4", ($urandom % 4) != 0, ms, qs);
        end
        begin
            int s = 0;
            for (int i = 0; i < NP; i++) s += model[i];
            check("R8", s, 0);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule